// File: doc/BRIEF.md
# Infrared Receive Run-Length Sampler

This block watches an already-filtered infrared receive line and turns what it sees into bytes for a 16-entry receive FIFO. The line is looked at only on cycles where the sample-tick strobe is high. A configuration register picks one of four ways to do this. In period-sample mode, every stretch of constant level becomes one code byte. The byte holds the level in its top bit and the stretch length, counted in ticks and minus one, in the low seven bits. In the two over-sampling modes, the block packs eight successive samples into a byte, MSB first. The re-synchronising variant restarts the byte boundary at every edge of the line. In loop-test mode, the CPU writes bytes straight into the FIFO.

The CPU reads the FIFO through a first-word-fall-through port with an empty flag. It reads a status register holding data-ready, overrun and time-out flags. An optional inversion bit swaps the meaning of high and low on the line before any mode uses it.

Top module: `irrx_sampler`

## Requirements
- R1: After reset the status register (address 0) reads 0x00, the configuration register (address 1) reads 0x00, and `fifo_empty` is 1.
- R2: The configuration register holds the mode in bits 7:6 and the inversion control in bit 0. Bits 5:1 read back as 0. A write to it discards any unfinished run or partially packed byte.
- R3: In mode 00, each run of constant level seen on tick cycles is closed when the level changes. It produces the byte {level, ticks-1}, where level 1 means a high line. The line is ignored on cycles with `tick` low.
- R4: A run that reaches 128 ticks is closed at once with length field 127. The next tick starts a new run, even if the level is the same.
- R5: With the inversion bit set, the sampled level is complemented before use in every sampling mode.
- R6: In mode 01, eight consecutive tick samples form one byte, with the first sample in bit 7.
- R7: In mode 10, a sample that differs from the previous one discards the partial byte. That sample becomes bit 7 of a new byte.
- R8: In mode 11, a write to address 0 pushes the written byte into the FIFO, and the receive line produces nothing.
- R9: Status bit 0 (data ready) reads 1 while the FIFO holds at least one byte, and 0 otherwise.
- R10: A byte that arrives while the FIFO holds 16 entries is dropped and sets status bit 1 (overrun). A status read clears the overrun bit.
- R11: Status bit 2 (time-out) is set when the FIFO is non-empty and TIMEOUT_TICKS ticks pass with no byte written. A status read clears it, and it is not set again until a new byte is written.
- R12: `fifo_dout` shows the oldest byte whenever `fifo_empty` is 0, and a cycle with `fifo_rd` high removes it. Bytes leave in the order they were produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one cycle per sample period |
| rx_in | input | 1 | Filtered infrared receive line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status / test data, 1 = configuration |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| fifo_rd | input | 1 | Pop the oldest FIFO byte |
| fifo_dout | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no bytes |

## Verification
A corrupted run counter or level register changes the very next code byte. That byte reaches `fifo_dout` two cycles after the tick that closes the run, so the scoreboard catches it on the first run that follows. A wrong bit counter in the packing modes shows up as shifted bytes within eight ticks. A wrong FIFO occupancy shows up as a lost or extra byte, or as a wrong data-ready or overrun bit on the next status read. A stuck idle counter is exposed by status reads taken one tick before and one tick at the time-out boundary.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  typedef enum logic [1:0] {
    MODE_PERIOD   = 2'b00,
    MODE_OVS      = 2'b01,
    MODE_OVS_SYNC = 2'b10,
    MODE_LOOP     = 2'b11
  } smode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/irrx_runlen.sv
module irrx_runlen #(
  parameter int LEN_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic           tick,
  input  logic           smp,
  output logic           out_valid,
  output logic [LEN_W:0] out_byte
);
  localparam logic [LEN_W-1:0] LAST = LEN_W'((2 ** LEN_W) - 2);

  logic             run_valid;
  logic             level;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_valid <= 1'b0;
      level     <= 1'b0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (en && tick) begin
        if (!run_valid) begin
          run_valid <= 1'b1;
          level     <= smp;
          cnt       <= '0;
        end else if (smp != level) begin
          out_valid <= 1'b1;
          out_byte  <= {level, cnt};
          level     <= smp;
          cnt       <= '0;
        end else if (cnt == LAST) begin
          out_valid <= 1'b1;
          out_byte  <= {level, {LEN_W{1'b1}}};
          run_valid <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: the stored length never reaches the saturated value
  p_len_cap_r4: assert property (@(posedge clk) disable iff (rst)
    run_valid |-> (cnt <= LAST));

  // R3: a level change closes the run with the old level in the top bit
  p_emit_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !clr && run_valid && (smp != level))
      |=> (out_valid && (out_byte[LEN_W] == $past(level))));
endmodule

// File: rtl/irrx_oversample.sv
module irrx_oversample #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         resync,
  input  logic         tick,
  input  logic         smp,
  output logic         out_valid,
  output logic [W-1:0] out_byte
);
  localparam int            BC_W  = $clog2(W);
  localparam logic [BC_W-1:0] LASTB = BC_W'(W - 1);

  logic [W-1:0]    sr;
  logic [BC_W-1:0] bc;
  logic            prev;
  logic            prev_valid;
  logic            edge_seen;

  assign edge_seen = resync && prev_valid && (smp != prev);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr         <= '0;
      bc         <= '0;
      prev       <= 1'b0;
      prev_valid <= 1'b0;
      out_valid  <= 1'b0;
      out_byte   <= '0;
    end else begin
      out_valid <= 1'b0;
      if (en && tick) begin
        prev       <= smp;
        prev_valid <= 1'b1;
        if (edge_seen) begin
          sr <= {{(W-1){1'b0}}, smp};
          bc <= BC_W'(1);
        end else begin
          sr <= {sr[W-2:0], smp};
          if (bc == LASTB) begin
            out_valid <= 1'b1;
            out_byte  <= {sr[W-2:0], smp};
            bc        <= '0;
          end else begin
            bc <= bc + 1'b1;
          end
        end
      end
    end
  end

  // R7: an edge in re-sync mode restarts the packing count
  p_edge_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !clr && edge_seen) |=> (bc == BC_W'(1) && !out_valid));
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop,
  output logic         wr_ok
);
  localparam int          AW   = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          rd_ok;

  assign empty = (count == '0);
  assign full  = (count == FULL);
  assign rd_ok = rd && !empty;
  assign wr_ok = wr && (!full || rd_ok);
  assign drop  = wr && !wr_ok;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: occupancy never passes the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);

  // R12: popping an empty FIFO leaves it empty
  p_pop_empty_r12: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !wr) |=> empty);
endmodule

// File: rtl/irrx_sampler.sv
module irrx_sampler
  import irrx_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_TICKS = 64,
  parameter int LEN_W         = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       fifo_rd,
  output logic [7:0] fifo_dout,
  output logic       fifo_empty
);
  localparam int            TO_W   = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(TIMEOUT_TICKS);

  smode_e            mode_q;
  logic              inv_q;
  logic              cfg_wr, st_rd, smp;
  logic              rl_en, os_en, resync, loop_push;
  logic              rl_v, os_v;
  logic [LEN_W:0]    rl_b;
  logic [BYTE_W-1:0] os_b;
  logic              push;
  logic [BYTE_W-1:0] push_b;
  logic              full, drop, push_acc;
  logic              ovr_q, to_q;
  logic [TO_W-1:0]   idle_q;

  assign cfg_wr    = reg_wr && reg_addr;
  assign st_rd     = reg_rd && !reg_addr;
  assign smp       = rx_in ^ inv_q;
  assign rl_en     = (mode_q == MODE_PERIOD);
  assign os_en     = (mode_q == MODE_OVS) || (mode_q == MODE_OVS_SYNC);
  assign resync    = (mode_q == MODE_OVS_SYNC);
  assign loop_push = reg_wr && !reg_addr && (mode_q == MODE_LOOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PERIOD;
      inv_q  <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= smode_e'(reg_wdata[7:6]);
      inv_q  <= reg_wdata[0];
    end
  end

  irrx_runlen #(.LEN_W(LEN_W)) u_runlen (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(rl_en), .tick(tick), .smp(smp),
    .out_valid(rl_v), .out_byte(rl_b)
  );

  irrx_oversample #(.W(BYTE_W)) u_ovs (
    .clk(clk), .rst(rst), .clr(cfg_wr), .en(os_en), .resync(resync),
    .tick(tick), .smp(smp), .out_valid(os_v), .out_byte(os_b)
  );

  always_comb begin
    push   = 1'b0;
    push_b = '0;
    if (loop_push) begin
      push   = 1'b1;
      push_b = reg_wdata;
    end else if (rl_v) begin
      push   = 1'b1;
      push_b = BYTE_W'(rl_b);
    end else if (os_v) begin
      push   = 1'b1;
      push_b = os_b;
    end
  end

  irrx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .wr(push), .din(push_b), .rd(fifo_rd),
    .dout(fifo_dout), .empty(fifo_empty), .full(full), .drop(drop),
    .wr_ok(push_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q     <= 1'b0;
      to_q      <= 1'b0;
      idle_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (drop)       ovr_q <= 1'b1;
      else if (st_rd) ovr_q <= 1'b0;

      if (fifo_empty || push_acc) idle_q <= '0;
      else if (tick && idle_q != TO_LIM) idle_q <= idle_q + 1'b1;

      if (!fifo_empty && !push_acc && tick && idle_q == TO_LIM - 1'b1) to_q <= 1'b1;
      else if (st_rd) to_q <= 1'b0;

      if (reg_rd) begin
        if (reg_addr) reg_rdata <= {mode_q, 5'b0, inv_q};
        else          reg_rdata <= {5'b0, to_q, ovr_q, !fifo_empty};
      end
    end
  end

  // R10: a dropped byte always leaves the overrun flag set
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr_q);

  // R11: the idle limit reached on a tick raises the time-out flag
  p_timeout_r11: assert property (@(posedge clk) disable iff (rst)
    (tick && !fifo_empty && !push_acc && idle_q == TO_LIM - 1'b1) |=> to_q);

  // R8: in loop-test mode the samplers stay silent
  p_loop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOOP && !cfg_wr) |=> !(rl_v || os_v));
endmodule

// File: tb/tb_irrx_sampler.sv
module tb_irrx_sampler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, rx_in = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       fifo_rd = 1'b0;
  logic [7:0] fifo_dout;
  logic       fifo_empty;

  int checks = 0, errors = 0, cycles = 0;
  bit mon_en = 1'b0;
  logic [7:0] q_data[$];
  string      q_tag[$];

  irrx_sampler #(.DEPTH(16), .TIMEOUT_TICKS(10), .LEN_W(7)) dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout),
    .fifo_empty(fifo_empty)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] b);
    q_data.push_back(b);
    q_tag.push_back(tag);
  endtask

  // scoreboard monitor: pops whenever the FIFO shows data
  always @(negedge clk) begin
    if (mon_en && !fifo_empty) begin
      checks++;
      if (q_data.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected byte %h expected none", fifo_dout);
      end else begin
        if (fifo_dout !== q_data[0]) begin
          errors++;
          $display("FAIL %s: got %h expected %h", q_tag[0], fifo_dout, q_data[0]);
        end
        void'(q_data.pop_front());
        void'(q_tag.pop_front());
      end
      fifo_rd <= 1'b1;
    end else begin
      fifo_rd <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    tick = 1'b0; reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  // n tick samples at level lvl; line toggled on the gap cycles (must be ignored)
  task automatic drive(input logic lvl, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_in = lvl; tick = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        tick = 1'b0; rx_in = ~lvl;
      end
    end
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) drive(b[i], 1, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    tick = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (q_data.size() == 0 && fifo_empty) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(tag, 8'(q_data.size()), 8'd0);
    chk(tag, {7'b0, fifo_empty}, 8'd1);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", {7'b0, fifo_empty}, 8'd1);
    rd(1'b0, v); chk("R1 status", v, 8'h00);
    rd(1'b1, v); chk("R1 config", v, 8'h00);
    // R2 readback with spare bits masked
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R2 config readback", v, 8'hC1);
    mon_en = 1'b1;

    // R3 period mode, tick every cycle
    wr(1'b1, 8'h00);
    drive(1'b1, 5, 0);
    expect_byte("R3 high run", 8'h84);
    drive(1'b0, 3, 0);
    expect_byte("R3 low run", 8'h02);
    drive(1'b1, 1, 0);
    expect_byte("R3 single", 8'h80);
    expect_byte("R4 long split", 8'h7F);
    drive(1'b0, 130, 0);
    expect_byte("R4 remainder", 8'h01);
    drive(1'b1, 2, 0);
    drain("R3 drain");

    // R4 exact 128-tick boundary
    wr(1'b1, 8'h00);
    expect_byte("R4 exact 128", 8'hFF);
    drive(1'b1, 128, 0);
    drive(1'b0, 1, 0);
    expect_byte("R4 fresh run", 8'h00);
    drive(1'b1, 1, 0);
    drain("R4 drain");

    // R5 inversion with tick gaps (R3 gap samples ignored); R2 open run discarded by this write
    wr(1'b1, 8'h01);
    drive(1'b1, 4, 2);
    expect_byte("R5 inverted high", 8'h03);
    drive(1'b0, 2, 2);
    expect_byte("R5 inverted low", 8'h81);
    drive(1'b1, 1, 2);
    drain("R5 drain");

    // R6 over-sampling, MSB first
    wr(1'b1, 8'h40);
    expect_byte("R6 byte A5", 8'hA5);
    send_bits(8'hA5);
    expect_byte("R6 byte 3C", 8'h3C);
    send_bits(8'h3C);
    drain("R6 drain");
    wr(1'b1, 8'h41);
    expect_byte("R5 ovs inverted", 8'hF0);
    send_bits(8'h0F);
    drain("R5 ovs drain");

    // R7 re-sync: 111 discarded at edge, then 8 zeros, then 8 ones
    wr(1'b1, 8'h80);
    expect_byte("R7 zeros", 8'h00);
    expect_byte("R7 ones", 8'hFF);
    drive(1'b1, 3, 0);
    drive(1'b0, 8, 0);
    drive(1'b1, 8, 0);
    drain("R7 drain");

    // R8 loop-test mode, line ignored
    wr(1'b1, 8'hC0);
    drive(1'b1, 9, 1);
    drive(1'b0, 9, 1);
    expect_byte("R8 write 5A", 8'h5A);
    wr(1'b0, 8'h5A);
    expect_byte("R8 write C3", 8'hC3);
    wr(1'b0, 8'hC3);
    drain("R8 drain");
    rd(1'b0, v); chk("R9 no data", v, 8'h00);

    // R10 overrun
    mon_en = 1'b0;
    for (int i = 0; i < 17; i++) wr(1'b0, 8'(i + 16));
    rd(1'b0, v); chk("R10 overrun set", v, 8'h03);
    rd(1'b0, v); chk("R10 overrun cleared", v, 8'h01);
    for (int i = 0; i < 16; i++) expect_byte("R10 kept", 8'(i + 16));
    mon_en = 1'b1;
    drain("R10 drain");

    // R11 time-out at 10 ticks
    mon_en = 1'b0;
    wr(1'b0, 8'h77);
    ticks(9);
    rd(1'b0, v); chk("R11 before limit", v, 8'h01);
    ticks(1);
    rd(1'b0, v); chk("R11 at limit", v, 8'h05);
    ticks(3);
    rd(1'b0, v); chk("R11 cleared", v, 8'h01);
    expect_byte("R12 fifo order", 8'h77);
    mon_en = 1'b1;
    drain("R11 drain");
    rd(1'b0, v); chk("R9 empty again", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule